// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block drives an asynchronous DRAM module that takes its address in two halves, row first and column second, on one shared address bus. A client presents a command (read, write or refresh) together with a linear byte address and write data. The block breaks the address into a row half and a column half using a split width that is set while the system runs. It then steps the active-low row strobes (one per bank), the column strobe and the write enable through a fixed order of phases. For a read it returns the sampled byte with a one-cycle completion pulse.

Each strobe phase lasts a number of clock cycles that is also set at run time, and every access ends with a precharge gap in which all strobes are high. An internal timer requests a column-before-row refresh on both banks at a fixed interval. That request takes priority over the next client command, but it never cuts into an access that has already started.

Top module: `dram_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, both row strobes, the column strobe and the write enable are high, the data bus is not driven, `done` and `rdata` are 0, and `req_ready` is 1.
- R2: With split width n, the row presented is `(req_addr >> n)` masked to n bits and the column is `req_addr` masked to n bits. After reset n is 12.
- R3: Writes to configuration (`cfg_sel` 0 = split width, 1 = bank count, 2 = phase length) are ignored when out of range: width outside 1..12, bank count other than 1 or 2, phase length 0. The reset values are width 12, one bank, and phase length 1.
- R4: With two banks configured, address bit 2n selects the bank (0 drives `ras_n[0]` low, 1 drives `ras_n[1]` low). With one bank, bank 0 is always used. At most one row strobe is low outside refresh.
- R5: A write (`req_cmd` 01) passes through these phases: data driven with WE low and the row presented; the row strobe falls; the column is presented and CAS falls; the row strobe rises; CAS rises; the data bus is released; then the precharge gap, in which WE is high again.
- R6: A read (`req_cmd` 00) keeps WE high and the bus undriven. It presents the row, then lowers the row strobe, then presents the column and lowers CAS. It then raises the row strobe and then CAS. `rdata` takes the value on `dq_in` in the last cycle of the column phase, and holds it until the next read captures.
- R7: A refresh (`req_cmd` 10 or 11, or from the internal timer) lowers CAS, then lowers both row strobes together, then raises CAS, then raises both row strobes.
- R8: Every phase, and the precharge gap with all strobes high, lasts exactly the configured phase length. That length is taken when the command starts.
- R9: `req_ready` is high only when idle with no refresh pending. A command is taken when `req_valid` and `req_ready` are both high at a clock edge. `done` pulses for one cycle in the first idle cycle after a client command, and not after a timer refresh.
- R10: A refresh becomes pending every REFRESH_PERIOD cycles. It is started ahead of a waiting client command when the sequencer is idle, and it does not change or interrupt an access already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration item: 0 width, 1 bank count, 2 phase length |
| cfg_val | input | HOLD_W | Configuration value |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Command can be taken |
| req_cmd | input | 2 | 00 read, 01 write, 1x refresh |
| req_addr | input | 2*ROW_W+1 | Linear byte address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last captured read data |
| dram_a | output | ROW_W | Multiplexed row/column address |
| ras_n | output | 2 | Row strobes, one per bank, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | DATA_W | Data to memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DATA_W | Data from memory |

## Verification
The hardest case to reach is a timer refresh becoming due while an access is in progress and a client command is already waiting. The sequencer must then finish the access, hold `req_ready` low, and run the refresh before it takes the waiting command. The bench shortens the refresh interval and keeps `req_valid` high across long runs of back-to-back reads and writes with a longer phase length. The timer's expiry therefore falls at many different points inside accesses, and sometimes on the idle cycle itself.

// File: rtl/dram_seq_pkg.sv
// Shared types for the DRAM access sequencer.
// Assumes: one command in flight at a time; phases are walked in enum order with per-command skips.
package dram_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_REFRESH = 2'b10
    } op_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ROW,
        PH_COL,
        PH_REL1,
        PH_REL2,
        PH_REL3,
        PH_PRE
    } phase_t;

    // Active-high view of the strobes for one phase.
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
        logic use_col;
    } strobe_t;

endpackage

// File: rtl/dram_seq_cfg.sv
// Run-time configuration registers: split width, bank count, phase length.
// Assumes: cfg_val is wide enough to hold ROW_W; writes with out-of-range values are dropped.
module dram_seq_cfg #(
    parameter int ROW_W  = 12,
    parameter int AW_W   = 4,
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [HOLD_W-1:0] cfg_val,
    output logic [AW_W-1:0]   abits,
    output logic              two_banks,
    output logic [HOLD_W-1:0] hold
);

    logic width_ok;
    logic banks_ok;
    logic hold_ok;

    // Range checks on the incoming value for each item.
    always_comb begin
        width_ok = (cfg_val != '0) && (int'(cfg_val) <= ROW_W);
        banks_ok = (int'(cfg_val) == 1) || (int'(cfg_val) == 2);
        hold_ok  = (cfg_val != '0);
    end

    // Register update, ignoring illegal values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abits     <= AW_W'(ROW_W);
            two_banks <= 1'b0;
            hold      <= HOLD_W'(1);
        end else if (cfg_wr) begin
            case (cfg_sel)
                2'd0: if (width_ok) abits <= AW_W'(cfg_val);
                2'd1: if (banks_ok) two_banks <= (int'(cfg_val) == 2);
                2'd2: if (hold_ok) hold <= cfg_val;
                default: ;
            endcase
        end
    end

    assert_width_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (abits != '0) && (int'(abits) <= ROW_W));

    assert_hold_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold != '0);

endmodule

// File: rtl/dram_seq_ref_timer.sv
// Refresh interval timer: raises a pending flag every PERIOD cycles, cleared on grant.
// Assumes: PERIOD >= 2; a new expiry in the grant cycle keeps the flag set.
module dram_seq_ref_timer #(
    parameter int PERIOD = 1560,
    parameter int CNT_W  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic pending
);

    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = (cnt == CNT_W'(PERIOD - 1));

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (expire) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // Pending flag: set on expiry, cleared when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (expire) pending <= 1'b1;
        else if (grant)  pending <= 1'b0;
    end

    assert_pending_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !grant) |=> pending);

endmodule

// File: rtl/dram_seq_split.sv
// Address splitter: row and column halves of a linear address for a run-time width, plus bank bit.
// Assumes: abits is in 1..ROW_W (guaranteed by the configuration block).
module dram_seq_split #(
    parameter int ROW_W  = 12,
    parameter int AW_W   = 4,
    parameter int ADDR_W = 25
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [AW_W-1:0]   abits,
    input  logic              two_banks,
    output logic [ROW_W-1:0]  row,
    output logic [ROW_W-1:0]  col,
    output logic              bank
);

    logic [ROW_W-1:0]  mask;
    logic [ADDR_W-1:0] row_shift;
    logic [ADDR_W-1:0] bank_shift;

    // Barrel shifts and masking for the configured width.
    always_comb begin
        mask       = {ROW_W{1'b1}} >> (ROW_W - int'(abits));
        row_shift  = addr >> abits;
        bank_shift = addr >> {abits, 1'b0};
        row        = row_shift[ROW_W-1:0] & mask;
        col        = addr[ROW_W-1:0] & mask;
        bank       = two_banks & bank_shift[0];
    end

endmodule

// File: rtl/dram_seq_ctrl.sv
// Phase sequencer: takes commands, steps strobes phase by phase, captures read data.
// Assumes: row/col/bank are valid in the accept cycle; phase length is latched at start.
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int DATA_W = 8,
    parameter int HOLD_W = 4,
    parameter int NUM_RAS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_cmd,
    input  logic [ROW_W-1:0]   row,
    input  logic [ROW_W-1:0]   col,
    input  logic               bank,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [HOLD_W-1:0]  hold,
    input  logic               ref_pending,
    input  logic [DATA_W-1:0]  dq_in,
    output logic               req_ready,
    output logic               ref_grant,
    output logic [ROW_W-1:0]   dram_a,
    output logic [NUM_RAS-1:0] ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe,
    output logic               done,
    output logic [DATA_W-1:0]  rdata
);

    phase_t              ph;
    phase_t              ph_nxt;
    op_t                 op;
    op_t                 op_in;
    logic                host;
    logic [ROW_W-1:0]    row_q;
    logic [ROW_W-1:0]    col_q;
    logic                bank_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [HOLD_W-1:0]   hold_q;
    logic [HOLD_W-1:0]   cnt;
    logic                idle;
    logic                ph_end;
    strobe_t             st;

    assign idle      = (ph == PH_IDLE);
    assign req_ready = idle && !ref_pending;
    assign ref_grant = idle && ref_pending;
    assign ph_end    = !idle && (cnt == hold_q - 1'b1);
    assign op_in     = req_cmd[1] ? OP_REFRESH : (req_cmd[0] ? OP_WRITE : OP_READ);

    // Next phase, with per-command skips.
    always_comb begin
        case (ph)
            PH_SETUP: ph_nxt = PH_ROW;
            PH_ROW:   ph_nxt = (op == OP_REFRESH) ? PH_REL1 : PH_COL;
            PH_COL:   ph_nxt = PH_REL1;
            PH_REL1:  ph_nxt = (op == OP_WRITE) ? PH_REL2 : PH_PRE;
            PH_REL2:  ph_nxt = PH_REL3;
            PH_REL3:  ph_nxt = PH_PRE;
            default:  ph_nxt = PH_IDLE;
        endcase
    end

    // Phase state, phase counter and command latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            op      <= OP_READ;
            host    <= 1'b0;
            cnt     <= '0;
            hold_q  <= HOLD_W'(1);
            row_q   <= '0;
            col_q   <= '0;
            bank_q  <= 1'b0;
            wdata_q <= '0;
        end else if (idle) begin
            cnt <= '0;
            if (ref_pending) begin
                ph     <= PH_SETUP;
                op     <= OP_REFRESH;
                host   <= 1'b0;
                hold_q <= hold;
            end else if (req_valid) begin
                ph      <= PH_SETUP;
                op      <= op_in;
                host    <= 1'b1;
                hold_q  <= hold;
                row_q   <= row;
                col_q   <= col;
                bank_q  <= bank;
                wdata_q <= wdata;
            end
        end else if (ph_end) begin
            cnt <= '0;
            ph  <= ph_nxt;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Completion pulse and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= (ph == PH_PRE) && ph_end && host;
            if ((ph == PH_COL) && ph_end && (op == OP_READ)) rdata <= dq_in;
        end
    end

    // Strobe pattern for the current command and phase.
    always_comb begin
        st = '0;
        case (op)
            OP_REFRESH: begin
                case (ph)
                    PH_SETUP: st.cas = 1'b1;
                    PH_ROW:   begin st.cas = 1'b1; st.ras = 1'b1; end
                    PH_REL1:  st.ras = 1'b1;
                    default:  ;
                endcase
            end
            OP_WRITE: begin
                case (ph)
                    PH_SETUP: begin st.we = 1'b1; st.oe = 1'b1; end
                    PH_ROW:   begin st.we = 1'b1; st.oe = 1'b1; st.ras = 1'b1; end
                    PH_COL:   begin st.we = 1'b1; st.oe = 1'b1; st.ras = 1'b1; st.cas = 1'b1; st.use_col = 1'b1; end
                    PH_REL1:  begin st.we = 1'b1; st.oe = 1'b1; st.cas = 1'b1; st.use_col = 1'b1; end
                    PH_REL2:  begin st.we = 1'b1; st.oe = 1'b1; st.use_col = 1'b1; end
                    PH_REL3:  begin st.we = 1'b1; st.use_col = 1'b1; end
                    default:  ;
                endcase
            end
            default: begin
                case (ph)
                    PH_ROW:  st.ras = 1'b1;
                    PH_COL:  begin st.ras = 1'b1; st.cas = 1'b1; st.use_col = 1'b1; end
                    PH_REL1: begin st.cas = 1'b1; st.use_col = 1'b1; end
                    default: ;
                endcase
            end
        endcase
    end

    // One row strobe per bank; refresh lowers all of them.
    for (genvar i = 0; i < NUM_RAS; i++) begin : g_ras
        assign ras_n[i] = !(st.ras && ((op == OP_REFRESH) || (bank_q == 1'(i))));
    end

    assign cas_n  = !st.cas;
    assign we_n   = !st.we;
    assign dq_oe  = st.oe;
    assign dq_out = wdata_q;
    assign dram_a = st.use_col ? col_q : row_q;

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> ((&ras_n) && cas_n && we_n && !dq_oe));

    assert_drive_only_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !we_n);

    assert_cas_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_REFRESH) && $fell(ras_n[0])) |-> (!cas_n && $past(!cas_n)));

    assert_one_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_REFRESH) |-> ($countones(~ras_n) <= 1));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_phase_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (cnt < hold_q));

    assert_no_preempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(op));

endmodule

// File: rtl/dram_seq.sv
// Top: DRAM access sequencer with run-time address split, two banks and timed refresh.
// Assumes: dq_out/dq_oe feed an external tristate; dq_in is stable in the column phase of reads.
module dram_seq #(
    parameter int ROW_W          = 12,
    parameter int DATA_W         = 8,
    parameter int HOLD_W         = 4,
    parameter int REFRESH_PERIOD = 1560,
    localparam int ADDR_W        = 2 * ROW_W + 1,
    localparam int AW_W          = $clog2(ROW_W + 1),
    localparam int TMR_W         = $clog2(REFRESH_PERIOD + 1),
    localparam int NUM_RAS       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_sel,
    input  logic [HOLD_W-1:0]  cfg_val,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_cmd,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output logic [ROW_W-1:0]   dram_a,
    output logic [NUM_RAS-1:0] ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe,
    input  logic [DATA_W-1:0]  dq_in
);

    logic [AW_W-1:0]   abits;
    logic              two_banks;
    logic [HOLD_W-1:0] hold;
    logic              ref_pending;
    logic              ref_grant;
    logic [ROW_W-1:0]  row;
    logic [ROW_W-1:0]  col;
    logic              bank;

    dram_seq_cfg #(.ROW_W(ROW_W), .AW_W(AW_W), .HOLD_W(HOLD_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
        .abits(abits), .two_banks(two_banks), .hold(hold)
    );

    dram_seq_ref_timer #(.PERIOD(REFRESH_PERIOD), .CNT_W(TMR_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .grant(ref_grant), .pending(ref_pending)
    );

    dram_seq_split #(.ROW_W(ROW_W), .AW_W(AW_W), .ADDR_W(ADDR_W)) i_split (
        .addr(req_addr), .abits(abits), .two_banks(two_banks),
        .row(row), .col(col), .bank(bank)
    );

    dram_seq_ctrl #(.ROW_W(ROW_W), .DATA_W(DATA_W), .HOLD_W(HOLD_W), .NUM_RAS(NUM_RAS)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .row(row), .col(col), .bank(bank), .wdata(req_wdata), .hold(hold),
        .ref_pending(ref_pending), .dq_in(dq_in), .req_ready(req_ready), .ref_grant(ref_grant),
        .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .done(done), .rdata(rdata)
    );

    assert_ready_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pending |-> !req_ready);

endmodule

// File: tb/test_dram_seq.sv
// Bench: behavioural reference model (queues of expected per-cycle bus states), compared every cycle.
module test_dram_seq;

    localparam int CLK_P  = 10;
    localparam int REF_P  = 45;
    localparam int ROW_W  = 12;
    localparam int ADDR_W = 2 * ROW_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [3:0]        cfg_val = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_wdata = '0;
    logic              done;
    logic [7:0]        rdata;
    logic [11:0]       dram_a;
    logic [1:0]        ras_n;
    logic              cas_n;
    logic              we_n;
    logic [7:0]        dq_out;
    logic              dq_oe;
    logic [7:0]        dq_in = '0;

    always #(CLK_P / 2) clk = ~clk;

    dram_seq #(.REFRESH_PERIOD(REF_P)) i_dram_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rdata(rdata), .dram_a(dram_a), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string scen = "R1";

    // Reference model state.
    logic [4:0]  q_ctl[$];
    logic [11:0] q_a[$];
    bit          q_achk[$];
    bit          q_cap[$];
    bit          q_fin[$];
    int          q_tag[$];
    int          m_abits = 12;
    bit          m_two = 0;
    int          m_hold = 1;
    bit          m_pend = 0;
    int          m_tmr = 0;
    bit          m_done = 0;
    logic [7:0]  m_rdata = '0;
    logic [7:0]  m_wdata = '0;

    function automatic string tag_name(int t);
        case (t)
            5: return "R5 write";
            6: return "R6 read";
            7: return "R7 refresh";
            default: return "R8 precharge";
        endcase
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [scenario %s] act=%h exp=%h t=%0t", what, scen, act, exp, $time);
        end
    endtask

    task automatic push_ph(logic [4:0] ctl, logic [11:0] a, bit achk, int tag);
        for (int k = 0; k < m_hold; k++) begin
            q_ctl.push_back(ctl); q_a.push_back(a); q_achk.push_back(achk);
            q_cap.push_back(0); q_fin.push_back(0); q_tag.push_back(tag);
        end
    endtask

    // Build the expected cycle sequence of one command. ctl = {ras_n[1:0], cas_n, we_n, oe}.
    task automatic build(logic [1:0] c, longint ad, logic [7:0] wd, bit hostop);
        longint mask, row, col, bnk;
        logic [1:0] rb;
        mask = (64'd1 << m_abits) - 1;
        row  = (ad >> m_abits) & mask;
        col  = ad & mask;
        bnk  = m_two ? ((ad >> (2 * m_abits)) & 1) : 0;
        rb   = (bnk != 0) ? 2'b01 : 2'b10;
        m_wdata = wd;
        if (c[1]) begin
            push_ph({2'b11, 1'b0, 1'b1, 1'b0}, '0, 0, 7);
            push_ph({2'b00, 1'b0, 1'b1, 1'b0}, '0, 0, 7);
            push_ph({2'b00, 1'b1, 1'b1, 1'b0}, '0, 0, 7);
        end else if (c[0]) begin
            push_ph({2'b11, 1'b1, 1'b0, 1'b1}, 12'(row), 1, 5);
            push_ph({rb,    1'b1, 1'b0, 1'b1}, 12'(row), 1, 5);
            push_ph({rb,    1'b0, 1'b0, 1'b1}, 12'(col), 1, 5);
            push_ph({2'b11, 1'b0, 1'b0, 1'b1}, 12'(col), 1, 5);
            push_ph({2'b11, 1'b1, 1'b0, 1'b1}, 12'(col), 1, 5);
            push_ph({2'b11, 1'b1, 1'b0, 1'b0}, 12'(col), 1, 5);
        end else begin
            push_ph({2'b11, 1'b1, 1'b1, 1'b0}, 12'(row), 1, 6);
            push_ph({rb,    1'b1, 1'b1, 1'b0}, 12'(row), 1, 6);
            push_ph({rb,    1'b0, 1'b1, 1'b0}, 12'(col), 1, 6);
            q_cap[q_cap.size() - 1] = 1;
            push_ph({2'b11, 1'b0, 1'b1, 1'b0}, 12'(col), 1, 6);
        end
        push_ph({2'b11, 1'b1, 1'b1, 1'b0}, '0, 0, 8);
        if (hostop) q_fin[q_fin.size() - 1] = 1;
    endtask

    // One cycle: compare outputs, advance the model, wait for the next falling edge.
    task automatic tick();
        bit nd;
        cyc++;
        dq_in = 8'(cyc * 37 + 11);
        if (q_ctl.size() == 0) begin
            check("R1/R8 idle strobes", {ras_n, cas_n, we_n, dq_oe}, 5'b11110);
            check("R9/R10 ready", req_ready, !m_pend);
        end else begin
            check(tag_name(q_tag[0]), {ras_n, cas_n, we_n, dq_oe}, q_ctl[0]);
            if (q_achk[0]) check("R2/R4 address bus", dram_a, q_a[0]);
            if (q_ctl[0][0]) check("R5 write data", dq_out, m_wdata);
            check("R9 ready busy", req_ready, 0);
        end
        check("R9 done", done, m_done);
        check("R6 rdata", rdata, m_rdata);
        nd = 0;
        if (q_ctl.size() != 0) begin
            if (q_cap[0]) m_rdata = dq_in;
            if (q_fin[0]) nd = 1;
            void'(q_ctl.pop_front()); void'(q_a.pop_front()); void'(q_achk.pop_front());
            void'(q_cap.pop_front()); void'(q_fin.pop_front()); void'(q_tag.pop_front());
        end else if (m_pend) begin
            build(2'b10, 0, 8'h00, 0);
            m_pend = 0;
        end else if (req_valid) begin
            build(req_cmd, longint'(req_addr), req_wdata, 1);
        end
        m_done = nd;
        if (cfg_wr) begin
            case (cfg_sel)
                2'd0: if (cfg_val >= 1 && cfg_val <= 12) m_abits = int'(cfg_val);
                2'd1: if (cfg_val == 1 || cfg_val == 2) m_two = (cfg_val == 2);
                2'd2: if (cfg_val != 0) m_hold = int'(cfg_val);
                default: ;
            endcase
        end
        m_tmr++;
        if (m_tmr == REF_P) begin
            m_pend = 1;
            m_tmr = 0;
        end
        @(negedge clk);
    endtask

    task automatic do_req(logic [1:0] c, longint ad, logic [7:0] wd);
        bit acc = 0;
        req_valid = 1; req_cmd = c; req_addr = ADDR_W'(ad); req_wdata = wd;
        while (!acc) begin
            acc = (q_ctl.size() == 0) && !m_pend;
            tick();
        end
        req_valid = 0;
    endtask

    task automatic settle();
        while (q_ctl.size() != 0) tick();
        tick();
    endtask

    task automatic cfg(logic [1:0] s, logic [3:0] v);
        settle();
        cfg_wr = 1; cfg_sel = s; cfg_val = v;
        tick();
        cfg_wr = 0;
    endtask

    task automatic access_pair(longint ad, logic [7:0] wd);
        do_req(2'b01, ad, wd);
        do_req(2'b00, ad, 8'h00);
        settle();
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset strobes", {ras_n, cas_n, we_n, dq_oe}, 5'b11110);
        check("R1 reset done", done, 0);
        check("R1 reset rdata", rdata, 0);
        check("R1 reset ready", req_ready, 1);
        rst_n = 1;

        scen = "R2";
        access_pair(25'h0ABC123, 8'h5A);
        scen = "R3";
        cfg(2'd0, 4'd0); cfg(2'd0, 4'd13); cfg(2'd1, 4'd3); cfg(2'd2, 4'd0);
        access_pair(25'h1FEDCBA, 8'hC3);
        scen = "R2";
        cfg(2'd0, 4'd8);
        access_pair(25'h0012345, 8'h0F);
        cfg(2'd0, 4'd1);
        access_pair(25'h0000006, 8'hF0);
        scen = "R4";
        cfg(2'd1, 4'd2); cfg(2'd0, 4'd4);
        access_pair(25'h0000123, 8'hAA);
        access_pair(25'h0000023, 8'h55);
        cfg(2'd0, 4'd12);
        access_pair(25'h1000001, 8'h30);
        cfg(2'd1, 4'd1);
        access_pair(25'h1000001, 8'h0C);
        scen = "R8";
        cfg(2'd2, 4'd3);
        access_pair(25'h0345678, 8'h03);
        scen = "R7";
        do_req(2'b10, 0, 8'h00);
        do_req(2'b11, 0, 8'h00);
        settle();
        scen = "R10";
        cfg(2'd2, 4'd2);
        for (int k = 0; k < 30; k++) begin
            do_req(2'(k % 2), longint'(k * 4099 + 17), 8'(k * 13));
        end
        cfg(2'd2, 4'd1);
        repeat (60) tick();
        for (int k = 0; k < 20; k++) begin
            do_req(2'(k % 3 == 0), longint'(k * 771), 8'(k + 1));
        end
        settle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL R9 watchdog: act=hung exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule